// File: doc/BRIEF.md
# Register Write Validator

This block sits on the command stream that feeds a 2D blitter. Each cycle it may receive one pair made of a register offset word and a value word. It decides whether that pair may be issued to the engine. It applies an offset window and an alignment rule to every pair. A mode input selects one of two register classes, and the block accepts only that class. In address mode it reads the buffer-kind tag in the top bit of the offset word, then clears that bit before it forwards the offset.

In plain mode, accepted writes to the stride, colour-mode and corner registers of the source and destination surfaces are captured into two descriptor sets. A later stage can bound-check a surface from these sets without parsing the list again. Each pair gets a sequence number, counted from zero since the last reset or clear. The feeder presents pairs newest first, so number i is the pair at list position last−2(i+1). The first rejected pair sets a sticky error flag and records its number.

Top module: `regwr_validator`

## Requirements
- R1: Only the low 12 bits of the offset word are tested against the window. A pair is rejected when those bits are below 0x104 or above 0x880. Both ends of the window are allowed.
- R2: A pair whose offset bits 1:0 are not zero is rejected.
- R3: In plain mode (addrMode = 0), the six base-address offsets are rejected: 0x304, 0x318, 0x404, 0x418, 0x500 and 0x520. Every other aligned in-window offset is accepted.
- R4: In address mode (addrMode = 1), only those six base-address offsets are accepted. Any other offset is rejected, including the stride, colour-mode and corner offsets.
- R5: In address mode, resUserBuf is 1 for an accepted pair whose offset bit 31 is 1, and the forwarded resOffset has bit 31 cleared. When bit 31 is 0 the buffer is of the managed kind and resUserBuf is 0. In plain mode, resUserBuf is 0 and resOffset equals the offset word as received.
- R6: An accepted plain write to 0x308 (source) or 0x408 (destination) stores the whole value as that surface's stride.
- R7: An accepted plain write to 0x30C or 0x40C stores value bits 3:0 as that surface's format.
- R8: An accepted plain write to 0x310/0x410 stores the left-top corner. An accepted plain write to 0x314/0x414 stores the right-bottom corner. In both cases x comes from value bits 12:0 and y from value bits 28:16.
- R9: A rejected pair changes no descriptor field.
- R10: Pairs are numbered from 0 in arrival order since reset or clear. The first rejected pair sets errFlag and loads its number into errIndex. Later pairs, good or bad, leave both unchanged.
- R11: The synchronous clear zeroes both descriptor sets, errFlag, errIndex and the pair numbering. A pair presented in the same cycle as clear is dropped and gives no result.
- R12: The result of a pair (resValid, resOk, resUserBuf, resOffset, resValue) appears on the clock edge that samples the pair. resValid is 0 in any cycle that follows a cycle with no pair. After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of descriptors, error and numbering |
| addrMode | input | 1 | 0 = plain-register mode, 1 = buffer-address mode |
| pairValid | input | 1 | A pair is presented this cycle |
| offsetWord | input | 32 | Register offset word; bit 31 is the buffer-kind tag in address mode |
| valueWord | input | 32 | Value to be written |
| resValid | output | 1 | Result of a pair is present |
| resOk | output | 1 | The pair may be issued |
| resUserBuf | output | 1 | Accepted address write refers to user memory |
| resOffset | output | 32 | Forwarded offset (tag bit cleared in address mode) |
| resValue | output | 32 | Forwarded value |
| errFlag | output | 1 | Sticky: some pair was rejected |
| errIndex | output | 8 | Number of the first rejected pair |
| srcStride | output | 32 | Source stride |
| srcFormat | output | 4 | Source format code |
| srcLeftX | output | 13 | Source left x |
| srcTopY | output | 13 | Source top y |
| srcRightX | output | 13 | Source right x |
| srcBottomY | output | 13 | Source bottom y |
| dstStride | output | 32 | Destination stride |
| dstFormat | output | 4 | Destination format code |
| dstLeftX | output | 13 | Destination left x |
| dstTopY | output | 13 | Destination top y |
| dstRightX | output | 13 | Destination right x |
| dstBottomY | output | 13 | Destination bottom y |

## Verification
A wrong classification shows up in resOk one cycle after the pair. A wrong surface select or field slice shows up at once on the descriptor ports, and the table walk reads these back after a mixed sequence of source and destination writes. If the pair counter or the sticky latch is wrong, errIndex holds the wrong number. This is visible as soon as the first bad pair lands, and it is checked again after a clear, with the failure placed at a different position.

// File: rtl/regwr_pkg.sv
package regwr_pkg;

  localparam int OFF_W = 12;

  // accepted offset window (inclusive) on the low OFF_W bits
  localparam logic [OFF_W-1:0] WIN_LO = 12'h104;
  localparam logic [OFF_W-1:0] WIN_HI = 12'h880;

  // buffer base-address registers
  localparam logic [OFF_W-1:0] A_SRC  = 12'h304;
  localparam logic [OFF_W-1:0] A_SRC2 = 12'h318;
  localparam logic [OFF_W-1:0] A_DST  = 12'h404;
  localparam logic [OFF_W-1:0] A_DST2 = 12'h418;
  localparam logic [OFF_W-1:0] A_PAT  = 12'h500;
  localparam logic [OFF_W-1:0] A_MSK  = 12'h520;

  // surface pages and descriptor slots inside a page
  localparam logic [3:0] PAGE_SRC = 4'h3;
  localparam logic [3:0] PAGE_DST = 4'h4;
  localparam logic [7:0] SLOT_STRIDE = 8'h08;
  localparam logic [7:0] SLOT_FMT    = 8'h0C;
  localparam logic [7:0] SLOT_LT     = 8'h10;
  localparam logic [7:0] SLOT_RB     = 8'h14;

  typedef enum logic [2:0] {
    DK_NONE,
    DK_STRIDE,
    DK_FMT,
    DK_LT,
    DK_RB
  } descKind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic accept;
    logic reject;
    logic addrPair;
    logic userBuf;
    logic toDst;
    logic capStride;
    logic capFmt;
    logic capLt;
    logic capRb;
  } strobe_t;

  function automatic logic isAddrReg(input logic [OFF_W-1:0] off);
    return (off == A_SRC) || (off == A_SRC2) || (off == A_DST) ||
           (off == A_DST2) || (off == A_PAT) || (off == A_MSK);
  endfunction

  function automatic descKind_e descKind(input logic [OFF_W-1:0] off);
    descKind_e k;
    k = DK_NONE;
    if (off[11:8] == PAGE_SRC || off[11:8] == PAGE_DST) begin
      case (off[7:0])
        SLOT_STRIDE: k = DK_STRIDE;
        SLOT_FMT:    k = DK_FMT;
        SLOT_LT:     k = DK_LT;
        SLOT_RB:     k = DK_RB;
        default:     k = DK_NONE;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/regwr_ctrl.sv
module regwr_ctrl
  import regwr_pkg::*;
(
  input  logic             pairValid,
  input  logic             clear,
  input  logic             addrMode,
  input  logic [OFF_W-1:0] offLow,
  input  logic             topBit,
  output strobe_t          strb
);

  logic      inWin;
  logic      aligned;
  logic      addrReg;
  logic      legal;
  logic      go;
  descKind_e kind;

  always_comb begin
    inWin   = (offLow >= WIN_LO) && (offLow <= WIN_HI);
    aligned = (offLow[1:0] == 2'b00);
    addrReg = isAddrReg(offLow);
    kind    = descKind(offLow);
    legal   = inWin && aligned && (addrMode ? addrReg : !addrReg);
    go      = pairValid && !clear;

    strb           = '0;
    strb.accept    = go && legal;
    strb.reject    = go && !legal;
    strb.addrPair  = go && addrMode;
    strb.userBuf   = go && legal && addrMode && topBit;
    strb.toDst     = (offLow[11:8] == PAGE_DST);
    strb.capStride = go && legal && !addrMode && (kind == DK_STRIDE);
    strb.capFmt    = go && legal && !addrMode && (kind == DK_FMT);
    strb.capLt     = go && legal && !addrMode && (kind == DK_LT);
    strb.capRb     = go && legal && !addrMode && (kind == DK_RB);
  end

endmodule

// File: rtl/regwr_dp.sv
module regwr_dp
  import regwr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 13,
  parameter int FMT_W   = 4,
  parameter int IDX_W   = 8,
  parameter int Y_LSB   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clear,
  input  strobe_t                 strb,
  input  logic [DATA_W-1:0]       offsetWord,
  input  logic [DATA_W-1:0]       valueWord,
  output logic                    resValid,
  output logic                    resOk,
  output logic                    resUserBuf,
  output logic [DATA_W-1:0]       resOffset,
  output logic [DATA_W-1:0]       resValue,
  output logic                    errFlag,
  output logic [IDX_W-1:0]        errIndex,
  output logic [1:0][DATA_W-1:0]  dStride,
  output logic [1:0][FMT_W-1:0]   dFormat,
  output logic [1:0][COORD_W-1:0] dLeftX,
  output logic [1:0][COORD_W-1:0] dTopY,
  output logic [1:0][COORD_W-1:0] dRightX,
  output logic [1:0][COORD_W-1:0] dBottomY
);

  localparam int NSURF = 2;

  logic [IDX_W-1:0]  pairCount;
  logic [DATA_W-1:0] fwdOffset;
  logic              pairSeen;

  assign pairSeen  = strb.accept || strb.reject;
  assign fwdOffset = strb.addrPair ? {1'b0, offsetWord[DATA_W-2:0]} : offsetWord;

  // per-pair result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      resOk      <= 1'b0;
      resUserBuf <= 1'b0;
      resOffset  <= '0;
      resValue   <= '0;
    end else begin
      resValid   <= pairSeen;
      resOk      <= strb.accept;
      resUserBuf <= strb.userBuf;
      if (pairSeen) begin
        resOffset <= fwdOffset;
        resValue  <= valueWord;
      end
    end
  end

  // numbering and first-failure latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairCount <= '0;
      errFlag   <= 1'b0;
      errIndex  <= '0;
    end else if (clear) begin
      pairCount <= '0;
      errFlag   <= 1'b0;
      errIndex  <= '0;
    end else if (pairSeen) begin
      pairCount <= pairCount + 1'b1;
      if (strb.reject && !errFlag) begin
        errFlag  <= 1'b1;
        errIndex <= pairCount;
      end
    end
  end

  // surface descriptor sets: index 0 source, 1 destination
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dStride  <= '0;
      dFormat  <= '0;
      dLeftX   <= '0;
      dTopY    <= '0;
      dRightX  <= '0;
      dBottomY <= '0;
    end else if (clear) begin
      dStride  <= '0;
      dFormat  <= '0;
      dLeftX   <= '0;
      dTopY    <= '0;
      dRightX  <= '0;
      dBottomY <= '0;
    end else begin
      for (int s = 0; s < NSURF; s++) begin
        if (strb.toDst == (s == 1)) begin
          if (strb.capStride) dStride[s] <= valueWord;
          if (strb.capFmt)    dFormat[s] <= valueWord[FMT_W-1:0];
          if (strb.capLt) begin
            dLeftX[s] <= valueWord[COORD_W-1:0];
            dTopY[s]  <= valueWord[Y_LSB +: COORD_W];
          end
          if (strb.capRb) begin
            dRightX[s]  <= valueWord[COORD_W-1:0];
            dBottomY[s] <= valueWord[Y_LSB +: COORD_W];
          end
        end
      end
    end
  end

endmodule

// File: rtl/regwr_validator.sv
module regwr_validator
  import regwr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 13,
  parameter int FMT_W   = 4,
  parameter int IDX_W   = 8,
  parameter int Y_LSB   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clear,
  input  logic               addrMode,
  input  logic               pairValid,
  input  logic [DATA_W-1:0]  offsetWord,
  input  logic [DATA_W-1:0]  valueWord,
  output logic               resValid,
  output logic               resOk,
  output logic               resUserBuf,
  output logic [DATA_W-1:0]  resOffset,
  output logic [DATA_W-1:0]  resValue,
  output logic               errFlag,
  output logic [IDX_W-1:0]   errIndex,
  output logic [DATA_W-1:0]  srcStride,
  output logic [FMT_W-1:0]   srcFormat,
  output logic [COORD_W-1:0] srcLeftX,
  output logic [COORD_W-1:0] srcTopY,
  output logic [COORD_W-1:0] srcRightX,
  output logic [COORD_W-1:0] srcBottomY,
  output logic [DATA_W-1:0]  dstStride,
  output logic [FMT_W-1:0]   dstFormat,
  output logic [COORD_W-1:0] dstLeftX,
  output logic [COORD_W-1:0] dstTopY,
  output logic [COORD_W-1:0] dstRightX,
  output logic [COORD_W-1:0] dstBottomY
);

  strobe_t                 strb;
  logic [1:0][DATA_W-1:0]  dStride;
  logic [1:0][FMT_W-1:0]   dFormat;
  logic [1:0][COORD_W-1:0] dLeftX;
  logic [1:0][COORD_W-1:0] dTopY;
  logic [1:0][COORD_W-1:0] dRightX;
  logic [1:0][COORD_W-1:0] dBottomY;

  regwr_ctrl u_ctrl (
    .pairValid (pairValid),
    .clear     (clear),
    .addrMode  (addrMode),
    .offLow    (offsetWord[OFF_W-1:0]),
    .topBit    (offsetWord[DATA_W-1]),
    .strb      (strb)
  );

  regwr_dp #(
    .DATA_W  (DATA_W),
    .COORD_W (COORD_W),
    .FMT_W   (FMT_W),
    .IDX_W   (IDX_W),
    .Y_LSB   (Y_LSB)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .clear      (clear),
    .strb       (strb),
    .offsetWord (offsetWord),
    .valueWord  (valueWord),
    .resValid   (resValid),
    .resOk      (resOk),
    .resUserBuf (resUserBuf),
    .resOffset  (resOffset),
    .resValue   (resValue),
    .errFlag    (errFlag),
    .errIndex   (errIndex),
    .dStride    (dStride),
    .dFormat    (dFormat),
    .dLeftX     (dLeftX),
    .dTopY      (dTopY),
    .dRightX    (dRightX),
    .dBottomY   (dBottomY)
  );

  assign srcStride  = dStride[0];
  assign srcFormat  = dFormat[0];
  assign srcLeftX   = dLeftX[0];
  assign srcTopY    = dTopY[0];
  assign srcRightX  = dRightX[0];
  assign srcBottomY = dBottomY[0];
  assign dstStride  = dStride[1];
  assign dstFormat  = dFormat[1];
  assign dstLeftX   = dLeftX[1];
  assign dstTopY    = dTopY[1];
  assign dstRightX  = dRightX[1];
  assign dstBottomY = dBottomY[1];

endmodule

// File: rtl/regwr_checker.sv
module regwr_checker #(
  parameter int DATA_W = 32,
  parameter int FMT_W  = 4,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              clear,
  input logic              addrMode,
  input logic              pairValid,
  input logic [DATA_W-1:0] offsetWord,
  input logic              resValid,
  input logic              resOk,
  input logic              resUserBuf,
  input logic [DATA_W-1:0] resOffset,
  input logic              errFlag,
  input logic [IDX_W-1:0]  errIndex,
  input logic [DATA_W-1:0] srcStride,
  input logic [DATA_W-1:0] dstStride,
  input logic [FMT_W-1:0]  srcFormat
);

  p_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && !clear && (offsetWord[11:0] < 12'h104 || offsetWord[11:0] > 12'h880))
      |=> (resValid && !resOk));

  p_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && !clear && offsetWord[1:0] != 2'b00) |=> (resValid && !resOk));

  p_addr_class_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && !clear && addrMode) |=>
      (!resOk || resOffset[11:0] inside {12'h304, 12'h318, 12'h404, 12'h418, 12'h500, 12'h520}));

  p_user_tag_r5: assert property (@(posedge clk) disable iff (!rstN)
    resUserBuf |-> (resOk && !resOffset[DATA_W-1]));

  p_no_capture_r9: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resOk) |-> ($stable(srcStride) && $stable(dstStride) && $stable(srcFormat)));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clear) |=> (errFlag && $stable(errIndex)));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (!errFlag && !resValid && errIndex == '0 && srcStride == '0 && dstStride == '0));

  p_latency_r12: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && !clear) |=> resValid);

  p_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !pairValid |=> !resValid);

endmodule

bind regwr_validator regwr_checker #(
  .DATA_W (DATA_W),
  .FMT_W  (FMT_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clear      (clear),
  .addrMode   (addrMode),
  .pairValid  (pairValid),
  .offsetWord (offsetWord),
  .resValid   (resValid),
  .resOk      (resOk),
  .resUserBuf (resUserBuf),
  .resOffset  (resOffset),
  .errFlag    (errFlag),
  .errIndex   (errIndex),
  .srcStride  (srcStride),
  .dstStride  (dstStride),
  .srcFormat  (srcFormat)
);

// File: tb/sim_regwr_validator.sv
`timescale 1ns/1ps
module sim_regwr_validator;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clear = 1'b0;
  logic        addrMode = 1'b0;
  logic        pairValid = 1'b0;
  logic [31:0] offsetWord = '0;
  logic [31:0] valueWord = '0;
  logic        resValid, resOk, resUserBuf, errFlag;
  logic [31:0] resOffset, resValue, srcStride, dstStride;
  logic [7:0]  errIndex;
  logic [3:0]  srcFormat, dstFormat;
  logic [12:0] srcLeftX, srcTopY, srcRightX, srcBottomY;
  logic [12:0] dstLeftX, dstTopY, dstRightX, dstBottomY;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  regwr_validator u0 (
    .clk(clk), .rstN(rstN), .clear(clear), .addrMode(addrMode),
    .pairValid(pairValid), .offsetWord(offsetWord), .valueWord(valueWord),
    .resValid(resValid), .resOk(resOk), .resUserBuf(resUserBuf),
    .resOffset(resOffset), .resValue(resValue), .errFlag(errFlag), .errIndex(errIndex),
    .srcStride(srcStride), .srcFormat(srcFormat), .srcLeftX(srcLeftX), .srcTopY(srcTopY),
    .srcRightX(srcRightX), .srcBottomY(srcBottomY),
    .dstStride(dstStride), .dstFormat(dstFormat), .dstLeftX(dstLeftX), .dstTopY(dstTopY),
    .dstRightX(dstRightX), .dstBottomY(dstBottomY)
  );

  // {addrMode, offset, value, expected ok}
  localparam int NV = 23;
  localparam logic [65:0] TBL [NV] = '{
    {1'b0, 32'h0000_0104, 32'h0000_0001, 1'b1},  // R1 low edge
    {1'b0, 32'h0000_0880, 32'h0000_0002, 1'b1},  // R1 high edge
    {1'b0, 32'h0000_0100, 32'h0000_0003, 1'b0},  // R1 below
    {1'b0, 32'h0000_0884, 32'h0000_0004, 1'b0},  // R1 above
    {1'b0, 32'hFFFF_F308, 32'h0000_1000, 1'b1},  // R1 high bits ignored, R6 src stride
    {1'b0, 32'h0000_0106, 32'h0000_0005, 1'b0},  // R2 misaligned
    {1'b0, 32'h0000_0304, 32'h0000_0006, 1'b0},  // R3 address reg in plain mode
    {1'b0, 32'h0000_030C, 32'hFFFF_FFF7, 1'b1},  // R7 src format 7
    {1'b0, 32'h0000_0310, 32'hE005_E003, 1'b1},  // R8 src LT x3 y5
    {1'b0, 32'h0000_0314, 32'h0040_0080, 1'b1},  // R8 src RB x80 y40
    {1'b0, 32'h0000_0408, 32'h0000_2000, 1'b1},  // R6 dst stride
    {1'b0, 32'h0000_040C, 32'h0000_0002, 1'b1},  // R7 dst format 2
    {1'b0, 32'h0000_0410, 32'h0001_0002, 1'b1},  // R8 dst LT x2 y1
    {1'b0, 32'h0000_0414, 32'h1FFF_1FFF, 1'b1},  // R8 dst RB max
    {1'b1, 32'h8000_0304, 32'h1111_0000, 1'b1},  // R5 user buffer
    {1'b1, 32'h0000_0418, 32'h2222_0000, 1'b1},  // R4 managed
    {1'b1, 32'h0000_0520, 32'h3333_0000, 1'b1},  // R4
    {1'b1, 32'h0000_0308, 32'h0000_DEAD, 1'b0},  // R4 stride in addr mode, R9
    {1'b1, 32'h0000_0200, 32'h0000_0007, 1'b0},  // R4 plain reg in addr mode
    {1'b0, 32'h0000_030E, 32'h0000_0005, 1'b0},  // R9 misaligned format write
    {1'b1, 32'h8000_0500, 32'h4444_0000, 1'b1},  // R5
    {1'b0, 32'h0000_0500, 32'h0000_0008, 1'b0},  // R3
    {1'b0, 32'h8000_0200, 32'h0000_0009, 1'b1}   // R5 plain keeps bit 31
  };

  function automatic string rowTag(int i);
    case (i)
      0, 1, 2, 3:       return "R1";
      4, 10:            return "R6";
      5:                return "R2";
      6, 21:            return "R3";
      7, 11:            return "R7";
      8, 9, 12, 13:     return "R8";
      15, 16, 17, 18:   return "R4";
      19:               return "R9";
      default:          return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, result is registered at the next posedge, sample at next negedge
  task automatic sendPair(input logic m, input logic [31:0] o, input logic [31:0] v);
    addrMode   = m;
    offsetWord = o;
    valueWord  = v;
    pairValid  = 1'b1;
    @(negedge clk);
    pairValid  = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int firstFail;
    logic        m, ok;
    logic [31:0] o, v;
    firstFail = -1;

    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset resValid", {31'b0, resValid}, 32'd0);
    chk("R12 reset errFlag", {31'b0, errFlag}, 32'd0);
    chk("R12 reset srcStride", srcStride, 32'd0);
    chk("R12 reset dstRightX", {19'b0, dstRightX}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {m, o, v, ok} = TBL[i];
      sendPair(m, o, v);
      chk({rowTag(i), " resValid"}, {31'b0, resValid}, 32'd1);
      chk({rowTag(i), " resOk"}, {31'b0, resOk}, {31'b0, ok});
      chk({"R5 userBuf ", rowTag(i)}, {31'b0, resUserBuf}, {31'b0, ok & m & o[31]});
      chk({"R5 offset ", rowTag(i)}, resOffset, m ? {1'b0, o[30:0]} : o);
      chk({"R12 value ", rowTag(i)}, resValue, v);
      if (!ok && firstFail < 0) firstFail = i;
    end

    // R12 no pair -> no result
    @(negedge clk);
    chk("R12 idle resValid", {31'b0, resValid}, 32'd0);

    // descriptors after walk
    chk("R6 srcStride", srcStride, 32'h1000);
    chk("R6 dstStride", dstStride, 32'h2000);
    chk("R7 srcFormat", {28'b0, srcFormat}, 32'd7);
    chk("R7 dstFormat", {28'b0, dstFormat}, 32'd2);
    chk("R8 srcLeftX", {19'b0, srcLeftX}, 32'd3);
    chk("R8 srcTopY", {19'b0, srcTopY}, 32'd5);
    chk("R8 srcRightX", {19'b0, srcRightX}, 32'h80);
    chk("R8 srcBottomY", {19'b0, srcBottomY}, 32'h40);
    chk("R8 dstLeftX", {19'b0, dstLeftX}, 32'd2);
    chk("R8 dstTopY", {19'b0, dstTopY}, 32'd1);
    chk("R8 dstRightX", {19'b0, dstRightX}, 32'h1FFF);
    chk("R8 dstBottomY", {19'b0, dstBottomY}, 32'h1FFF);
    chk("R10 errFlag", {31'b0, errFlag}, 32'd1);
    chk("R10 errIndex first failure", {24'b0, errIndex}, firstFail);

    // R11 clear wins over a same-cycle pair
    clear      = 1'b1;
    pairValid  = 1'b1;
    addrMode   = 1'b0;
    offsetWord = 32'h0000_0308;
    valueWord  = 32'h0000_5555;
    @(negedge clk);
    clear     = 1'b0;
    pairValid = 1'b0;
    chk("R11 clear drops pair", {31'b0, resValid}, 32'd0);
    chk("R11 clear errFlag", {31'b0, errFlag}, 32'd0);
    chk("R11 clear errIndex", {24'b0, errIndex}, 32'd0);
    chk("R11 clear srcStride", srcStride, 32'd0);
    chk("R11 clear dstBottomY", {19'b0, dstBottomY}, 32'd0);
    chk("R11 clear srcFormat", {28'b0, srcFormat}, 32'd0);

    // R10 numbering restarts: pair 0 good, pair 1 bad, pair 2 bad
    sendPair(1'b0, 32'h0000_0200, 32'd1);
    chk("R10 good pair no error", {31'b0, errFlag}, 32'd0);
    sendPair(1'b1, 32'h0000_0310, 32'd2);
    chk("R10 errFlag set", {31'b0, errFlag}, 32'd1);
    chk("R10 errIndex 1", {24'b0, errIndex}, 32'd1);
    sendPair(1'b0, 32'h0000_0000, 32'd3);
    chk("R10 later failure keeps index", {24'b0, errIndex}, 32'd1);
    sendPair(1'b0, 32'h0000_0410, 32'h0007_0006);
    chk("R10 later good keeps flag", {31'b0, errFlag}, 32'd1);
    chk("R8 capture after error", {19'b0, dstTopY}, 32'd7);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule